// File: doc/BRIEF.md
# Per-Vector Message Interrupt Controller

This block raises interrupts as memory writes. Each interrupt vector owns one entry in a table that software programs: a 64-bit target address, a 32-bit data word and a mask bit. Because every vector has its own address and data, two vectors can be steered to different processors. Internal sources pulse a request line per vector. The block records each request in a pending bit and later turns it into exactly one write on a valid/acknowledge message port.

Unmasked pending vectors are served in rotating order. Each launch latches the entry's address and data into the output register. The launch is held back by a function-wide mask, and it is also held back while the device still has earlier data writes in flight, so that an interrupt write never overtakes them.

Top module: `vec_msg_irq`

## Requirements
- R1: After reset `msg_valid` is 0. Every entry reads back address 0, data 0 and mask bit 1, so all vectors start masked.
- R2: Register word address `reg_addr = vector*4 + w`. w=0 is address bits 31:0, w=1 is address bits 63:32, w=2 is the data word, and w=3 is control, where bit 0 is the mask and the other bits read 0. A write with `reg_wr_en` takes effect at the next clock edge. `reg_rdata` shows the current contents of the addressed word.
- R3: A request on a masked vector starts no message. The vector stays pending, and clearing its mask later yields exactly one message for it.
- R4: While `fn_mask` is 1 no new message is launched. Pending requests are kept and go out once `fn_mask` returns to 0.
- R5: While `dma_idle` is 0 no new message is launched. This keeps the interrupt write behind earlier data writes.
- R6: `msg_addr` and `msg_data` equal the vector's table entry as it stood in the launch cycle. They stay stable while `msg_valid` is held.
- R7: `msg_valid` stays 1 until `msg_ready` is seen and drops on the next edge. There is one message per acknowledge. A new launch can come no earlier than the cycle after the drop.
- R8: The eligible vector chosen is the first one after the last vector served, going upward and wrapping around. The first search after reset starts at vector 0.
- R9: A vector's pending bit is cleared when its message launches. A request that arrives in the launch cycle or later makes the vector pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | NUM_VEC | One-cycle request pulse per vector |
| fn_mask | input | 1 | Function-wide hold of all messages |
| dma_idle | input | 1 | 1 when no earlier data write from the device is outstanding |
| reg_wr_en | input | 1 | Table word write strobe |
| reg_addr | input | IDX_W+2 | Table word address |
| reg_wdata | input | 32 | Table write data |
| reg_rdata | output | 32 | Table read data for `reg_addr` |
| msg_valid | output | 1 | Interrupt write request |
| msg_ready | input | 1 | Acknowledge of the interrupt write |
| msg_addr | output | 64 | Target address of the write |
| msg_data | output | 32 | Data word of the write |

## Verification
The assertions assume that `msg_ready` is only meaningful while `msg_valid` is 1. They also assume that `dma_idle` truly reflects earlier outstanding writes, and that the table is only written through the register port. The stimulus drives every input half a cycle away from the sampling edge. It keeps register addresses inside the table, and it toggles requests, masks, `fn_mask`, `dma_idle` and `msg_ready` at random, with directed stretches for the masked, held and same-cycle re-request cases.

// File: rtl/vmi_pkg.sv
package vmi_pkg;
  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } word_sel_e;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msg_t;
endpackage

// File: rtl/vmi_rst_sync.sv
module vmi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_s  <= meta_q;
    end
  end
endmodule

// File: rtl/vmi_table.sv
module vmi_table #(
  parameter int NUM_VEC = 16,
  parameter int IDX_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W+1:0]     reg_addr,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  input  logic [IDX_W-1:0]     look_idx,
  output vmi_pkg::msg_t        look_msg,
  output logic [NUM_VEC-1:0]   mask_vec
);
  import vmi_pkg::*;

  logic [63:0]      ent_addr [NUM_VEC];
  logic [31:0]      ent_data [NUM_VEC];
  logic [IDX_W-1:0] r_idx;
  word_sel_e        r_word;

  assign r_idx  = reg_addr[IDX_W+1:2];
  assign r_word = word_sel_e'(reg_addr[1:0]);

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    logic [31:0] lo_q, lo_d, hi_q, hi_d, dat_q, dat_d;
    logic        msk_q, msk_d;
    logic        sel;

    assign sel = wr_en && (r_idx == IDX_W'(g));

    always_comb begin
      lo_d  = lo_q;
      hi_d  = hi_q;
      dat_d = dat_q;
      msk_d = msk_q;
      if (sel) begin
        case (r_word)
          W_ADDR_LO: lo_d  = wr_data;
          W_ADDR_HI: hi_d  = wr_data;
          W_DATA:    dat_d = wr_data;
          W_CTRL:    msk_d = wr_data[0];
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        dat_q <= '0;
        msk_q <= 1'b1;
      end else if (sel) begin
        lo_q  <= lo_d;
        hi_q  <= hi_d;
        dat_q <= dat_d;
        msk_q <= msk_d;
      end
    end

    assign ent_addr[g] = {hi_q, lo_q};
    assign ent_data[g] = dat_q;
    assign mask_vec[g] = msk_q;
  end

  always_comb begin
    rd_data = '0;
    if (32'(r_idx) < NUM_VEC) begin
      case (r_word)
        W_ADDR_LO: rd_data = ent_addr[r_idx][31:0];
        W_ADDR_HI: rd_data = ent_addr[r_idx][63:32];
        W_DATA:    rd_data = ent_data[r_idx];
        W_CTRL:    rd_data = {31'b0, mask_vec[r_idx]};
      endcase
    end
  end

  assign look_msg.addr = ent_addr[look_idx];
  assign look_msg.data = ent_data[look_idx];

  AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr[1:0] == 2'd3 && 32'(r_idx) < NUM_VEC)
      |=> mask_vec[$past(r_idx)] == $past(wr_data[0])); // R2
endmodule

// File: rtl/vmi_arbiter.sv
module vmi_arbiter #(
  parameter int NUM_VEC = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] req_vec,
  input  logic [NUM_VEC-1:0] mask_vec,
  input  logic               take,
  output logic               grant_any,
  output logic [IDX_W-1:0]   grant_idx
);
  logic [NUM_VEC-1:0] pend_q, pend_d, elig, clr;
  logic [IDX_W-1:0]   ptr_q, ptr_d;

  assign elig = pend_q & ~mask_vec;

  always_comb begin
    int k;
    grant_any = 1'b0;
    grant_idx = '0;
    k         = 0;
    for (int i = 1; i <= NUM_VEC; i++) begin
      k = (int'(ptr_q) + i) % NUM_VEC;
      if (!grant_any && elig[k]) begin
        grant_any = 1'b1;
        grant_idx = IDX_W'(k);
      end
    end
  end

  always_comb begin
    clr    = take ? (NUM_VEC'(1) << grant_idx) : '0;
    pend_d = (pend_q & ~clr) | req_vec;
    ptr_d  = take ? grant_idx : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ptr_q  <= IDX_W'(NUM_VEC - 1);
    end else begin
      pend_q <= pend_d;
      if (take) ptr_q <= ptr_d;
    end
  end

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_vec[grant_idx]) |=> !pend_q[$past(grant_idx)]); // R9
  AST_REREQ_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_vec[grant_idx]) |=> pend_q[$past(grant_idx)]); // R9
endmodule

// File: rtl/vec_msg_irq.sv
module vec_msg_irq #(
  parameter int NUM_VEC = 16,
  localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int RAW    = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic               fn_mask,
  input  logic               dma_idle,
  input  logic               reg_wr_en,
  input  logic [RAW-1:0]     reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  import vmi_pkg::*;

  logic               rst_s;
  logic [NUM_VEC-1:0] mask_vec;
  logic               grant_any;
  logic [IDX_W-1:0]   grant_idx;
  msg_t               look_msg;
  logic               launch;
  logic               valid_q, valid_d;
  msg_t               msg_q, msg_d;

  vmi_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  vmi_table #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr_en    (reg_wr_en),
    .reg_addr (reg_addr),
    .wr_data  (reg_wdata),
    .rd_data  (reg_rdata),
    .look_idx (grant_idx),
    .look_msg (look_msg),
    .mask_vec (mask_vec)
  );

  vmi_arbiter #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_s),
    .req_vec   (irq_req),
    .mask_vec  (mask_vec),
    .take      (launch),
    .grant_any (grant_any),
    .grant_idx (grant_idx)
  );

  assign launch = !valid_q && !fn_mask && dma_idle && grant_any;

  always_comb begin
    valid_d = valid_q;
    msg_d   = msg_q;
    if (valid_q && msg_ready) valid_d = 1'b0;
    if (launch) begin
      valid_d = 1'b1;
      msg_d   = look_msg;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (launch) msg_q <= msg_d;
    end
  end

  assign msg_valid = valid_q;
  assign msg_addr  = msg_q.addr;
  assign msg_data  = msg_q.data;

  AST_HOLD_CONTENT: assert property (@(posedge clk) disable iff (!rst_s)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R6
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_s)
    (msg_valid && msg_ready) |=> !msg_valid); // R7
  AST_FN_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_s)
    (fn_mask && !msg_valid) |=> !msg_valid); // R4
  AST_DMA_ORDER: assert property (@(posedge clk) disable iff (!rst_s)
    (!dma_idle && !msg_valid) |=> !msg_valid); // R5
  AST_LAUNCH_UNMASKED: assert property (@(posedge clk) disable iff (!rst_s)
    launch |-> !mask_vec[grant_idx]); // R3
endmodule

// File: tb/tb_vec_msg_irq.sv
module tb_vec_msg_irq;
  localparam int CLK_PERIOD = 10;
  localparam int NV  = 16;
  localparam int IW  = 4;
  localparam int RAW = IW + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NV-1:0] irq_req;
  logic          fn_mask, dma_idle, reg_wr_en, msg_ready;
  logic [RAW-1:0] reg_addr;
  logic [31:0]   reg_wdata, reg_rdata, msg_data;
  logic          msg_valid;
  logic [63:0]   msg_addr;

  vec_msg_irq #(.NUM_VEC(NV)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fn_mask(fn_mask),
    .dma_idle(dma_idle), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // staged inputs, applied at the falling edge by step
  logic [NV-1:0]  s_req;
  logic           s_we, s_fnm, s_dma, s_ack;
  logic [RAW-1:0] s_addr;
  logic [31:0]    s_wdata;

  // reference model
  logic [31:0] m_lo [NV];
  logic [31:0] m_hi [NV];
  logic [31:0] m_dat[NV];
  logic [NV-1:0] m_msk, m_pend;
  int          m_ptr;
  logic        m_valid;
  logic [63:0] m_addr;
  logic [31:0] m_data;

  function automatic logic [31:0] m_word(input logic [RAW-1:0] a);
    int v;
    v = int'(a[RAW-1:2]);
    case (a[1:0])
      2'd0:    return m_lo[v];
      2'd1:    return m_hi[v];
      2'd2:    return m_dat[v];
      default: return {31'b0, m_msk[v]};
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    int v;
    @(negedge clk);
    irq_req = s_req; reg_wr_en = s_we; reg_addr = s_addr; reg_wdata = s_wdata;
    fn_mask = s_fnm; dma_idle = s_dma; msg_ready = s_ack;
    v = -1;
    if (!m_valid && !s_fnm && s_dma)
      for (int i = 1; i <= NV; i++) begin
        int k;
        k = (m_ptr + i) % NV;
        if (v < 0 && m_pend[k] && !m_msk[k]) v = k;
      end
    if (m_valid && s_ack) m_valid = 1'b0;
    if (v >= 0) begin
      m_valid = 1'b1;
      m_addr  = {m_hi[v], m_lo[v]};
      m_data  = m_dat[v];
      m_ptr   = v;
      m_pend[v] = 1'b0;
    end
    m_pend = m_pend | s_req;
    if (s_we) begin
      case (s_addr[1:0])
        2'd0:    m_lo[s_addr[RAW-1:2]]  = s_wdata;
        2'd1:    m_hi[s_addr[RAW-1:2]]  = s_wdata;
        2'd2:    m_dat[s_addr[RAW-1:2]] = s_wdata;
        default: m_msk[s_addr[RAW-1:2]] = s_wdata[0];
      endcase
    end
    s_req = '0;
    s_we  = 1'b0;
    @(posedge clk);
    #1;
    chk(msg_valid === m_valid, tag, 64'(msg_valid), 64'(m_valid));
    if (m_valid) begin
      chk(msg_addr === m_addr, tag, msg_addr, m_addr);
      chk(msg_data === m_data, tag, 64'(msg_data), 64'(m_data));
    end
    chk(reg_rdata === m_word(s_addr), tag, 64'(reg_rdata), 64'(m_word(s_addr)));
  endtask

  task automatic wr(input int v, input int w, input logic [31:0] d, input string tag);
    s_we = 1'b1; s_addr = RAW'(v * 4 + w); s_wdata = d;
    step(tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    for (int v = 0; v < NV; v++) begin
      m_lo[v] = '0; m_hi[v] = '0; m_dat[v] = '0;
    end
    m_msk = '1; m_pend = '0; m_ptr = NV - 1; m_valid = 1'b0; m_addr = '0; m_data = '0;
    s_req = '0; s_we = 1'b0; s_fnm = 1'b0; s_dma = 1'b1; s_ack = 1'b0;
    s_addr = '0; s_wdata = '0;
    irq_req = '0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    fn_mask = 1'b0; dma_idle = 1'b1; msg_ready = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step("R1");

    // R1: reset contents of every word
    for (int a = 0; a < NV * 4; a++) begin
      s_addr = RAW'(a);
      step("R1");
    end

    // R2: program distinct routing per vector, unmask all but vector 3
    for (int v = 0; v < NV; v++) begin
      wr(v, 0, 32'h4000_0000 + 32'(v * 8), "R2");
      wr(v, 1, 32'h0000_00f0 + 32'(v), "R2");
      wr(v, 2, 32'hd000_0000 | 32'(v), "R2");
      if (v != 3) wr(v, 3, 32'hffff_fffe, "R2");
    end

    // R3: masked vector keeps pending, one message after unmask
    s_req = NV'(1) << 3;
    step("R3");
    repeat (4) step("R3");
    chk(msg_valid === 1'b0, "R3", 64'(msg_valid), 64'd0);
    wr(3, 3, 32'd0, "R3");
    step("R3");
    chk(msg_valid === 1'b1 && msg_data === 32'hd000_0003, "R3", 64'(msg_data), 64'hd000_0003);
    s_ack = 1'b1;
    repeat (3) step("R7");
    chk(msg_valid === 1'b0, "R7", 64'(msg_valid), 64'd0);

    // R4: function mask holds several requests, then order follows R8
    s_ack = 1'b0; s_fnm = 1'b1;
    s_req = (NV'(1) << 1) | (NV'(1) << 9) | (NV'(1) << 5);
    repeat (5) step("R4");
    chk(msg_valid === 1'b0, "R4", 64'(msg_valid), 64'd0);
    s_fnm = 1'b0;
    step("R8");
    chk(msg_data === 32'hd000_0005, "R8", 64'(msg_data), 64'hd000_0005);
    s_ack = 1'b1;
    step("R8"); s_ack = 1'b0; step("R8");
    chk(msg_data === 32'hd000_0009, "R8", 64'(msg_data), 64'hd000_0009);
    s_ack = 1'b1;
    step("R8"); s_ack = 1'b0; step("R8");
    chk(msg_data === 32'hd000_0001, "R8", 64'(msg_data), 64'hd000_0001);
    s_ack = 1'b1;
    repeat (2) step("R7");

    // R5: outstanding data writes hold the message back
    s_dma = 1'b0; s_ack = 1'b0;
    s_req = NV'(1) << 12;
    repeat (4) step("R5");
    chk(msg_valid === 1'b0, "R5", 64'(msg_valid), 64'd0);
    s_dma = 1'b1;
    step("R5");
    // R6: rewrite entry while held, emitted values stay
    wr(12, 2, 32'h1234_5678, "R6");
    repeat (2) step("R6");
    chk(msg_data === 32'hd000_000c, "R6", 64'(msg_data), 64'hd000_000c);
    s_ack = 1'b1;
    repeat (2) step("R7");

    // R9: request again in the launch cycle
    s_ack = 1'b0;
    s_req = NV'(1) << 7;
    step("R9");
    s_req = NV'(1) << 7;
    step("R9");
    s_ack = 1'b1; step("R9");
    s_ack = 1'b0; step("R9");
    chk(msg_valid === 1'b1 && msg_data === 32'hd000_0007, "R9", 64'(msg_data), 64'hd000_0007);
    s_ack = 1'b1;
    repeat (2) step("R9");

    // random mix
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 3 == 0) s_req = NV'(1) << ($urandom % NV);
      if ($urandom % 4 == 0) begin
        s_we = 1'b1;
        s_wdata = $urandom;
      end
      s_addr = RAW'($urandom % (NV * 4));
      if ($urandom % 40 == 0) s_fnm = ~s_fnm;
      s_dma = ($urandom % 5 != 0);
      s_ack = ($urandom % 2 == 0);
      step("R2/R6/R7/R8/R9");
    end

    finish_run();
  end
endmodule